// File: doc/BRIEF.md
# MAC Pause and Backpressure Transmit Gate

This block decides when a MAC transmitter may start a new frame. A received pause time is loaded into a quanta counter. The counter counts down in pause quanta, and each quantum is a fixed number of byte-time ticks. While the count is nonzero, no new frame is granted. A frame already granted always runs to its end, so gating happens only at frame boundaries.

Three test controls go around the normal path. A shortcut control shrinks the quantum to a single byte-time so that long pauses can be tested quickly. A forced-pause control blocks frame starts exactly as a nonzero received pause would. A backpressure control asks the transmitter to send preamble, which raises carrier on a half-duplex link. During backpressure a system frame is still granted, and the jam resumes once that frame ends.

Top module: `mac_pause_gate`

## Requirements
- R1: With `tst_short_quanta` low, one pause quantum equals 64 asserted `byte_tick` cycles. Cycles without `byte_tick` do not advance the count. A pause of N quanta blocks frame starts until the 64·N-th tick after the load.
- R2: With `tst_short_quanta` high, one pause quantum equals one asserted `byte_tick` cycle. A pause of N releases on the N-th tick.
- R3: A `pause_rx_vld` strobe loads `pause_rx_time` into the counter. The new value replaces any count in progress and restarts the quantum from its first byte-time.
- R4: A loaded pause time of zero releases the pause at once. A waiting `tx_req` is granted in the cycle after the strobe.
- R5: While `tst_force_pause` is high, frame starts are blocked as if a nonzero pause were active. Once it is cleared, a waiting request is granted one cycle later.
- R6: With nothing inhibiting, `tx_allow` rises one clock after `tx_req` is seen high. It then stays high until `tx_frame_done` is seen, whatever pause or forced pause arrives in between.
- R7: While `tst_backpressure` is high and no frame is granted, `jam_req` is high. It is low while `tx_allow` is high, and it returns high after the frame ends if the bit is still set.
- R8: During and right after reset, `tx_allow` and `jam_req` are low and the pause count is zero. With test bits low, a request after reset is granted one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_tick | input | 1 | One-cycle pulse per byte-time |
| pause_rx_vld | input | 1 | Strobe: a received pause time is valid |
| pause_rx_time | input | 16 | Received pause time in quanta |
| tst_short_quanta | input | 1 | Test: quantum is one byte-time |
| tst_force_pause | input | 1 | Test: block frame starts |
| tst_backpressure | input | 1 | Test: request preamble jam |
| tx_req | input | 1 | System has a frame to send |
| tx_frame_done | input | 1 | Granted frame has ended |
| tx_allow | output | 1 | Frame granted; held for the whole frame |
| jam_req | output | 1 | Request to transmit preamble as backpressure |

## Verification
The bench counts a two-quantum pause to the exact tick, with idle cycles placed between ticks. A prescaler that runs without ticks, or that is off by one, would release a cycle early or late. It reloads a pause in the middle of a quantum, which catches a design that adds to the old count or keeps the old quantum phase. It also loads a zero pause, which catches a design that waits a quantum before releasing. Pauses and forced pauses that arrive in the middle of a frame check that a granted frame is never cut short. The backpressure sequence checks that the jam stops for a system frame and comes back after it, rather than staying high or never returning.

// File: rtl/mpg_pkg.sv
// Shared types for the pause and backpressure transmit gate.
// Assumes nothing beyond being compiled before its users.
package mpg_pkg;
    // Gate state: waiting for a frame start, or inside a granted frame
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_TX   = 1'b1
    } gate_state_e;
endpackage

// File: rtl/mpg_pause_timer.sv
// Pause quanta timer: holds the remaining pause in quanta and divides
// byte-time ticks into quanta with a prescaler.
// Assumes byte_tick is a single-cycle pulse and that a load strobe has
// priority over counting in the same cycle.
module mpg_pause_timer #(
    parameter int TIME_W  = 16,
    parameter int QUANTUM = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_tick,
    input  logic              load_vld,
    input  logic [TIME_W-1:0] load_val,
    input  logic              short_quanta,
    output logic              pause_active
);
    localparam int PRESC_W = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;

    logic [TIME_W-1:0]  quanta_left;
    logic               quantum_end;
    logic               step;

    // A quantum ends on a tick, at the prescaler's last byte-time or at once in shortcut mode
    generate
        if (QUANTUM > 1) begin : g_presc
            logic [PRESC_W-1:0] presc;
            assign quantum_end = short_quanta || (presc == PRESC_W'(QUANTUM - 1));

            // Prescaler: byte-times within the current quantum; restarted by a load
            always_ff @(posedge clk) begin
                if (!rst_n || load_vld || quanta_left == '0) begin
                    presc <= '0;
                end else if (byte_tick) begin
                    presc <= quantum_end ? '0 : presc + 1'b1;
                end
            end
        end else begin : g_nopresc
            assign quantum_end = 1'b1;
        end
    endgenerate

    assign step = byte_tick && quantum_end && (quanta_left != '0);

    // Remaining quanta: a load replaces the count, otherwise count down per quantum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quanta_left <= '0;
        end else if (load_vld) begin
            quanta_left <= load_val;
        end else if (step) begin
            quanta_left <= quanta_left - 1'b1;
        end
    end

    assign pause_active = (quanta_left != '0);

    // R3
    load_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> quanta_left == $past(load_val));

    // R1
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_vld |=> quanta_left <= $past(quanta_left));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_vld && !byte_tick) |=> $stable(quanta_left));

    // R2
    short_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_vld && byte_tick && short_quanta && quanta_left != '0)
        |=> quanta_left == $past(quanta_left) - 1'b1);
endmodule

// File: rtl/mpg_tx_gate.sv
// Transmit gate: grants a frame start only while nothing inhibits,
// holds the grant until the frame ends, and requests a preamble jam
// between frames while backpressure is selected.
// Assumes tx_frame_done is only meaningful while a frame is granted.
module mpg_tx_gate
    import mpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    input  logic tx_req,
    input  logic tx_frame_done,
    input  logic bp_mode,
    output logic tx_allow,
    output logic jam_req
);
    gate_state_e state;

    // Frame boundary tracking: start when permitted, stop at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GATE_IDLE;
        end else begin
            case (state)
                GATE_IDLE: if (tx_req && !inhibit) state <= GATE_TX;
                GATE_TX:   if (tx_frame_done)      state <= GATE_IDLE;
                default:   state <= GATE_IDLE;
            endcase
        end
    end

    // Grant output and jam request between frames
    always_comb begin
        tx_allow = (state == GATE_TX);
        jam_req  = bp_mode && (state == GATE_IDLE);
    end

    // R5
    no_start_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_allow && inhibit) |=> !tx_allow);

    // R6
    no_truncate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_allow && !tx_frame_done) |=> tx_allow);

    // R7
    jam_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_allow |-> !jam_req);
endmodule

// File: rtl/mac_pause_gate.sv
// MAC pause and backpressure transmit gate: combines the pause quanta
// timer, the forced-pause test control and the frame gate.
// Assumes all inputs are synchronous to clk.
module mac_pause_gate #(
    parameter int TIME_W  = 16,
    parameter int QUANTUM = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_tick,
    input  logic              pause_rx_vld,
    input  logic [TIME_W-1:0] pause_rx_time,
    input  logic              tst_short_quanta,
    input  logic              tst_force_pause,
    input  logic              tst_backpressure,
    input  logic              tx_req,
    input  logic              tx_frame_done,
    output logic              tx_allow,
    output logic              jam_req
);
    logic pause_active;
    logic inhibit;

    mpg_pause_timer #(
        .TIME_W  (TIME_W),
        .QUANTUM (QUANTUM)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_tick    (byte_tick),
        .load_vld     (pause_rx_vld),
        .load_val     (pause_rx_time),
        .short_quanta (tst_short_quanta),
        .pause_active (pause_active)
    );

    // A forced pause inhibits starts exactly as a received nonzero pause does
    assign inhibit = pause_active || tst_force_pause;

    mpg_tx_gate gate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .inhibit       (inhibit),
        .tx_req        (tx_req),
        .tx_frame_done (tx_frame_done),
        .bp_mode       (tst_backpressure),
        .tx_allow      (tx_allow),
        .jam_req       (jam_req)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !tx_allow && !pause_active);
endmodule

// File: tb/mac_pause_gate_tb_top.sv
module mac_pause_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_tick;
    logic        pause_rx_vld;
    logic [15:0] pause_rx_time;
    logic        tst_short_quanta;
    logic        tst_force_pause;
    logic        tst_backpressure;
    logic        tx_req;
    logic        tx_frame_done;
    logic        tx_allow;
    logic        jam_req;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mac_pause_gate dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .byte_tick        (byte_tick),
        .pause_rx_vld     (pause_rx_vld),
        .pause_rx_time    (pause_rx_time),
        .tst_short_quanta (tst_short_quanta),
        .tst_force_pause  (tst_force_pause),
        .tst_backpressure (tst_backpressure),
        .tx_req           (tx_req),
        .tx_frame_done    (tx_frame_done),
        .tx_allow         (tx_allow),
        .jam_req          (jam_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; byte_tick = 0; pause_rx_vld = 0; pause_rx_time = '0;
        tst_short_quanta = 0; tst_force_pause = 0; tst_backpressure = 0;
        tx_req = 0; tx_frame_done = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_pause(input logic [15:0] t);
        pause_rx_vld = 1; pause_rx_time = t;
        @(negedge clk);
        pause_rx_vld = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            byte_tick = 1; @(negedge clk);
        end
        byte_tick = 0;
    endtask

    task automatic end_frame();
        tx_frame_done = 1; tx_req = 0;
        @(negedge clk);
        tx_frame_done = 0;
    endtask

    // R8: reset state and first grant
    task automatic t_reset();
        rst_n = 1'b0; tx_req = 1; byte_tick = 0; pause_rx_vld = 0; pause_rx_time = '0;
        tst_short_quanta = 0; tst_force_pause = 0; tst_backpressure = 0; tx_frame_done = 0;
        repeat (2) @(negedge clk);
        check("R8 allow in reset", tx_allow, 1'b0);
        check("R8 jam in reset", jam_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 grant after reset", tx_allow, 1'b1);
        end_frame();
    endtask

    // R1: 64 byte-times per quantum, ticks with gaps
    task automatic t_normal_quanta();
        do_reset();
        load_pause(16'd2);
        tx_req = 1;
        for (int i = 0; i < 127; i++) begin
            byte_tick = 1; @(negedge clk);
            if (i % 16 == 5) begin byte_tick = 0; @(negedge clk); end
        end
        byte_tick = 0;
        check("R1 blocked before last tick", tx_allow, 1'b0);
        ticks(1);
        check("R1 blocked on last tick edge", tx_allow, 1'b0);
        @(negedge clk);
        check("R1 granted after 128 ticks", tx_allow, 1'b1);
        end_frame();
        check("R6 released after done", tx_allow, 1'b0);
    endtask

    // R2: shortcut quantum of one byte-time
    task automatic t_short_quanta();
        do_reset();
        tst_short_quanta = 1;
        load_pause(16'd3);
        tx_req = 1;
        ticks(2);
        check("R2 blocked after 2 of 3", tx_allow, 1'b0);
        ticks(1);
        check("R2 blocked on 3rd tick edge", tx_allow, 1'b0);
        @(negedge clk);
        check("R2 granted after 3 ticks", tx_allow, 1'b1);
        end_frame();
    endtask

    // R3: reload replaces count and restarts quantum phase
    task automatic t_reload();
        do_reset();
        tst_short_quanta = 1;
        load_pause(16'd10);
        ticks(4);
        load_pause(16'd2);
        tx_req = 1;
        ticks(1);
        @(negedge clk);
        check("R3 short reload still blocked", tx_allow, 1'b0);
        ticks(1);
        @(negedge clk);
        check("R3 short reload released", tx_allow, 1'b1);
        end_frame();
        tst_short_quanta = 0;
        load_pause(16'd1);
        ticks(40);
        load_pause(16'd1);
        tx_req = 1;
        ticks(63);
        @(negedge clk);
        check("R3 phase restarted, blocked", tx_allow, 1'b0);
        ticks(1);
        @(negedge clk);
        check("R3 phase restarted, released", tx_allow, 1'b1);
        end_frame();
    endtask

    // R4: zero pause releases at once
    task automatic t_zero();
        do_reset();
        load_pause(16'd100);
        tx_req = 1;
        @(negedge clk);
        check("R4 blocked by 100", tx_allow, 1'b0);
        tx_req = 0;
        load_pause(16'd0);
        tx_req = 1;
        @(negedge clk);
        check("R4 zero releases", tx_allow, 1'b1);
        end_frame();
    endtask

    // R5: forced pause
    task automatic t_force();
        do_reset();
        tst_force_pause = 1; tx_req = 1;
        repeat (5) begin
            @(negedge clk);
            check("R5 forced pause blocks", tx_allow, 1'b0);
        end
        tst_force_pause = 0;
        @(negedge clk);
        check("R5 grant after clear", tx_allow, 1'b1);
        end_frame();
    endtask

    // R6: pause never truncates a granted frame
    task automatic t_no_truncate();
        do_reset();
        tx_req = 1;
        @(negedge clk);
        check("R6 grant one cycle after req", tx_allow, 1'b1);
        load_pause(16'd5);
        tst_force_pause = 1;
        repeat (4) begin
            @(negedge clk);
            check("R6 frame held under pause", tx_allow, 1'b1);
        end
        tst_force_pause = 0;
        tx_frame_done = 1;
        @(negedge clk);
        tx_frame_done = 0;
        @(negedge clk);
        check("R6 paused after frame end", tx_allow, 1'b0);
        tx_req = 0;
    endtask

    // R7: backpressure jam around a system frame
    task automatic t_backpressure();
        do_reset();
        #1 check("R7 no jam with bit low", jam_req, 1'b0);
        tst_backpressure = 1;
        #1 check("R7 jam while idle", jam_req, 1'b1);
        tx_req = 1;
        @(negedge clk);
        check("R7 frame granted during jam", tx_allow, 1'b1);
        check("R7 jam off during frame", jam_req, 1'b0);
        end_frame();
        check("R7 jam resumes after frame", jam_req, 1'b1);
        tst_backpressure = 0;
        #1 check("R7 jam off when bit cleared", jam_req, 1'b0);
    endtask

    initial begin
        t_reset();
        t_normal_quanta();
        t_short_quanta();
        t_reload();
        t_zero();
        t_force();
        t_no_truncate();
        t_backpressure();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule